// File: doc/BRIEF.md
# Majority-Clocked Triple-LFSR Keystream Generator

This block produces a bit-serial keystream from three linear feedback shift registers of 19, 22 and 23 bits, 64 bits of state in all. A one-cycle `start` pulse while the block is idle captures a 64-bit session key and a 22-bit frame number. The three registers are cleared. The key bits and then the frame bits are folded into all three registers, one bit per cycle. After that, 100 mixing steps run and their output is thrown away. Finally, 228 keystream bits are emitted on consecutive cycles.

In the mixing and output phases the registers move by stop/go clocking. Each register has one clock-tap bit. The majority value of the three tap bits is formed on every step, and only the registers whose tap agrees with that majority advance. The 228 output bits form two 114-bit blocks, one for each direction of a link, and a flag tells them apart. A single-cycle completion pulse follows the last bit. XOR with payload data is done outside the block.

Top module: `maj_keystream_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ks_bit`, `ks_valid`, `blk_second` and `run_done` are all 0.
- R2: A `start` seen in the idle phase latches `key_in` and `frame_in` and clears all three registers to zero, so an all-zero key and frame yield 228 zero bits.
- R3: Loading runs 86 steps in which every register advances on every step. Key bit 0 is used first and key bit 63 last, followed by frame bits 0 through 21. The current bit is XORed into the feedback of all three registers.
- R4: Each register shifts toward its MSB and takes its feedback into bit 0. The feedback is the XOR of these bits: bits 18, 17, 16 and 13 for the 19-bit register, bits 21 and 20 for the 22-bit register, and bits 22, 21, 20 and 7 for the 23-bit register.
- R5: In the mixing and output phases the clock taps are bit 8, bit 10 and bit 10 (bit 0 is the LSB). A register advances only when its tap equals the majority of the three taps, so at least two registers advance on each such step.
- R6: After loading, 100 mixing steps run with `ks_valid` low. The first valid bit appears exactly 187 clock edges after the edge that accepted `start`.
- R7: `ks_valid` is high for exactly 228 consecutive cycles. Each `ks_bit` is the XOR of the three register MSBs after that step's clocking.
- R8: `blk_second` is 0 for output bits 0 to 113 and 1 for bits 114 to 227.
- R9: `run_done` is a one-cycle pulse in the cycle immediately after the last valid bit.
- R10: `start` and changes on `key_in` or `frame_in` have no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| key_in | input | 64 | Session key, LSB consumed first |
| frame_in | input | 22 | Frame number, LSB consumed first |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` is valid |
| blk_second | output | 1 | 0 = first 114-bit block, 1 = second |
| run_done | output | 1 | One-cycle pulse after the final bit |

## Verification
Any register bit that goes wrong during loading or mixing spreads through the feedback taps and the stop/go pattern. It shows up as keystream mismatches within the first few dozen valid bits of the run. Phase counting errors appear at the ports as a shifted first-valid cycle, as a wrong run length, or as a block flag or completion pulse out of place. The bench compares every bit of several runs against an arithmetic model, including a sweep over frame values. That sweep exposes tap, ordering or majority faults on the first run whose stream departs from the model.

// File: rtl/mks_pkg.sv
package mks_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_KEY   = 3'd1,
    PH_FRAME = 3'd2,
    PH_MIX   = 3'd3,
    PH_GEN   = 3'd4,
    PH_DONE  = 3'd5
  } phase_t;
endpackage

// File: rtl/mks_shift_reg.sv
module mks_shift_reg #(
  parameter int          LEN     = 19,
  parameter logic [31:0] FB_MASK = 32'h0007_2000,
  parameter int          CK_POS  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic inj,
  output logic msb_nxt,
  output logic ck_tap
);
  localparam logic [LEN-1:0] MASK = FB_MASK[LEN-1:0];

  logic [LEN-1:0] st_q;
  logic           fb;

  assign fb      = (^(st_q & MASK)) ^ inj;
  assign msb_nxt = adv ? st_q[LEN-2] : st_q[LEN-1];
  assign ck_tap  = st_q[CK_POS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st_q <= '0;
    end else if (adv) begin
      st_q <= {st_q[LEN-2:0], fb};
    end
  end
endmodule

// File: rtl/mks_vote.sv
module mks_vote #(
  parameter int NREG = 3
) (
  input  logic [NREG-1:0] taps,
  input  logic            step_en,
  input  logic            vote_en,
  output logic [NREG-1:0] adv
);
  logic maj;
  assign maj = (taps[0] & taps[1]) | (taps[0] & taps[2]) | (taps[1] & taps[2]);

  for (genvar g = 0; g < NREG; g++) begin : g_adv
    assign adv[g] = step_en & (~vote_en | (taps[g] == maj));
  end
endmodule

// File: rtl/mks_sequencer.sv
module mks_sequencer
  import mks_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter int FRM_W = 22,
  parameter int MIX_N = 100,
  parameter int GEN_N = 228,
  parameter int CW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [KEY_W-1:0]       key_in,
  input  logic [FRM_W-1:0]       frame_in,
  output phase_t                 phase_o,
  output logic [CW-1:0]          cnt_o,
  output logic                   clr_o,
  output logic                   step_o,
  output logic                   vote_o,
  output logic                   gen_o,
  output logic                   done_o,
  output logic                   load_bit_o
);
  localparam int LDW = KEY_W + FRM_W;
  localparam logic [CW-1:0] KEY_LAST = CW'(KEY_W - 1);
  localparam logic [CW-1:0] FRM_LAST = CW'(FRM_W - 1);
  localparam logic [CW-1:0] MIX_LAST = CW'(MIX_N - 1);
  localparam logic [CW-1:0] GEN_LAST = CW'(GEN_N - 1);

  phase_t          phase_q;
  logic [CW-1:0]   cnt_q;
  logic [LDW-1:0]  ld_sr;
  logic            loading;

  assign loading    = (phase_q == PH_KEY) || (phase_q == PH_FRAME);
  assign phase_o    = phase_q;
  assign cnt_o      = cnt_q;
  assign clr_o      = (phase_q == PH_IDLE) && start;
  assign vote_o     = (phase_q == PH_MIX) || (phase_q == PH_GEN);
  assign step_o     = loading || vote_o;
  assign gen_o      = (phase_q == PH_GEN);
  assign done_o     = (phase_q == PH_DONE);
  assign load_bit_o = loading & ld_sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ld_sr   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_KEY;
            cnt_q   <= '0;
            ld_sr   <= {frame_in, key_in};
          end
        end
        PH_KEY: begin
          ld_sr <= ld_sr >> 1;
          if (cnt_q == KEY_LAST) begin
            phase_q <= PH_FRAME;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FRAME: begin
          ld_sr <= ld_sr >> 1;
          if (cnt_q == FRM_LAST) begin
            phase_q <= PH_MIX;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_MIX: begin
          if (cnt_q == MIX_LAST) begin
            phase_q <= PH_GEN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_GEN: begin
          if (cnt_q == GEN_LAST) begin
            phase_q <= PH_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/maj_keystream_gen.sv
module maj_keystream_gen
  import mks_pkg::*;
#(
  parameter int          KEY_W = 64,
  parameter int          FRM_W = 22,
  parameter int          MIX_N = 100,
  parameter int          BLK_N = 114,
  parameter int          LEN0  = 19,
  parameter int          LEN1  = 22,
  parameter int          LEN2  = 23,
  parameter logic [31:0] FB0   = 32'h0007_2000,
  parameter logic [31:0] FB1   = 32'h0030_0000,
  parameter logic [31:0] FB2   = 32'h0070_0080,
  parameter int          CK0   = 8,
  parameter int          CK1   = 10,
  parameter int          CK2   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] key_in,
  input  logic [FRM_W-1:0] frame_in,
  output logic             ks_bit,
  output logic             ks_valid,
  output logic             blk_second,
  output logic             run_done
);
  localparam int NREG  = 3;
  localparam int GEN_N = 2 * BLK_N;
  localparam int M01   = (KEY_W > FRM_W) ? KEY_W : FRM_W;
  localparam int M23   = (MIX_N > GEN_N) ? MIX_N : GEN_N;
  localparam int MAXN  = (M01 > M23) ? M01 : M23;
  localparam int CW    = $clog2(MAXN + 1);
  localparam int          LENS [NREG] = '{LEN0, LEN1, LEN2};
  localparam logic [31:0] FBS  [NREG] = '{FB0, FB1, FB2};
  localparam int          CKS  [NREG] = '{CK0, CK1, CK2};

  phase_t          phase_w;
  logic [CW-1:0]   cnt_w;
  logic            clr_w, step_w, vote_w, gen_w, done_w, inj_w;
  logic [NREG-1:0] taps_w, adv_w, msb_nxt_w;

  mks_sequencer #(
    .KEY_W(KEY_W), .FRM_W(FRM_W), .MIX_N(MIX_N), .GEN_N(GEN_N), .CW(CW)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .key_in(key_in), .frame_in(frame_in),
    .phase_o(phase_w), .cnt_o(cnt_w), .clr_o(clr_w), .step_o(step_w),
    .vote_o(vote_w), .gen_o(gen_w), .done_o(done_w), .load_bit_o(inj_w)
  );

  mks_vote #(.NREG(NREG)) vote_i (
    .taps(taps_w), .step_en(step_w), .vote_en(vote_w), .adv(adv_w)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    mks_shift_reg #(
      .LEN(LENS[g]), .FB_MASK(FBS[g]), .CK_POS(CKS[g])
    ) sr_i (
      .clk(clk), .rst(rst), .clr(clr_w), .adv(adv_w[g]), .inj(inj_w),
      .msb_nxt(msb_nxt_w[g]), .ck_tap(taps_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit     <= 1'b0;
      ks_valid   <= 1'b0;
      blk_second <= 1'b0;
      run_done   <= 1'b0;
    end else begin
      ks_valid <= gen_w;
      ks_bit   <= gen_w & (^msb_nxt_w);
      run_done <= done_w;
      if (clr_w) begin
        blk_second <= 1'b0;
      end else if (gen_w) begin
        blk_second <= (cnt_w >= CW'(BLK_N));
      end
    end
  end
endmodule

// File: rtl/mks_checker.sv
module mks_checker
  import mks_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input phase_t     phase,
  input logic [2:0] adv,
  input logic       ks_valid,
  input logic       blk_second,
  input logic       run_done
);
  AST_LOAD_ALL_MOVE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_KEY || phase == PH_FRAME) |-> (adv == 3'b111)); // R3

  AST_TWO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MIX || phase == PH_GEN) |-> ($countones(adv) >= 2)); // R5

  AST_MIX_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MIX) |=> !ks_valid); // R6

  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ks_valid && blk_second) |=> (!ks_valid || blk_second)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    run_done |=> !run_done); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    run_done |-> ($past(ks_valid) && !ks_valid)); // R9

  AST_GEN_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GEN) |=> (phase == PH_GEN || phase == PH_DONE)); // R10
endmodule

bind maj_keystream_gen mks_checker chk_i (
  .clk(clk), .rst(rst), .phase(phase_w), .adv(adv_w),
  .ks_valid(ks_valid), .blk_second(blk_second), .run_done(run_done)
);

// File: tb/maj_keystream_gen_tb_top.sv
`timescale 1ns/1ps
module maj_keystream_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] key_in = '0;
  logic [21:0] frame_in = '0;
  logic        ks_bit, ks_valid, blk_second, run_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  maj_keystream_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .key_in(key_in), .frame_in(frame_in),
    .ks_bit(ks_bit), .ks_valid(ks_valid), .blk_second(blk_second), .run_done(run_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [227:0] model_stream(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    logic [227:0] s;
    logic in_b, m, fa, fb, fc;
    a = '0; b = '0; c = '0; s = '0;
    for (int i = 0; i < 86; i++) begin
      in_b = (i < 64) ? k[i] : f[i-64];
      fa = a[18] ^ a[17] ^ a[16] ^ a[13] ^ in_b;
      fb = b[21] ^ b[20] ^ in_b;
      fc = c[22] ^ c[21] ^ c[20] ^ c[7] ^ in_b;
      a = {a[17:0], fa}; b = {b[20:0], fb}; c = {c[21:0], fc};
    end
    for (int i = 0; i < 328; i++) begin
      m = (a[8] + b[10] + c[10]) >= 2;
      if (a[8] == m) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
      if (b[10] == m) b = {b[20:0], b[21] ^ b[20]};
      if (c[10] == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
      if (i >= 100) s[i-100] = a[18] ^ b[21] ^ c[22];
    end
    return s;
  endfunction

  // One full run; optionally pokes start and new inputs mid-run (R10).
  task automatic run_case(input logic [63:0] k, input logic [21:0] f, input bit poke);
    logic [227:0] exp_s;
    int idx, first_k, done_k, done_cnt;
    exp_s = model_stream(k, f);
    idx = 0; first_k = -1; done_k = -1; done_cnt = 0;
    @(negedge clk);
    key_in = k; frame_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int kk = 1; kk <= 420; kk++) begin
      if (poke && (kk == 100 || kk == 300)) begin
        start = 1'b1; key_in = ~k; frame_in = ~f;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (ks_valid) begin
        if (first_k < 0) first_k = kk;
        if (idx < 228) begin
          check(ks_bit == exp_s[idx], "R7", $sformatf("bit %0d", idx), ks_bit, exp_s[idx]);
          check(blk_second == (idx >= 114), "R8", $sformatf("block flag at bit %0d", idx),
                blk_second, idx >= 114);
        end
        idx++;
      end
      if (run_done) begin
        done_cnt++;
        if (done_k < 0) done_k = kk;
      end
    end
    start = 1'b0;
    check(first_k == 187, "R6", "first valid edge", first_k, 187);
    check(idx == 228, "R7", "valid bit count", idx, 228);
    check(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    check(done_k == 415, "R9", "done pulse edge", done_k, 415);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!ks_valid && !ks_bit && !blk_second && !run_done, "R1", "outputs in reset",
          {ks_valid, ks_bit, blk_second, run_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!ks_valid && !ks_bit && !blk_second && !run_done, "R1", "outputs after reset",
          {ks_valid, ks_bit, blk_second, run_done}, 0);

    // R2: zero key and frame after clear give a zero stream
    run_case(64'h0, 22'h0, 1'b0);
    // R3 ordering: single key LSB, single frame LSB, single key MSB
    run_case(64'h1, 22'h0, 1'b0);
    run_case(64'h0, 22'h1, 1'b0);
    run_case(64'h8000_0000_0000_0000, 22'h0, 1'b0);
    // R4 / R5 on dense patterns, R10 with mid-run pokes
    run_case(64'h0123_4567_89AB_CDEF, 22'h2A_5A5, 1'b1);
    run_case(64'hFFFF_FFFF_FFFF_FFFF, 22'h3F_FFFF, 1'b1);
    // Sweep over low frame values with a fixed key (R3 R5)
    for (int fv = 0; fv < 8; fv++) begin
      run_case(64'hA5C3_0F96_1E2D_7B48, 22'(fv), 1'b0);
    end

    // R1: reset in the middle of a run silences the outputs
    @(negedge clk);
    key_in = 64'h1357_9BDF_0246_8ACE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (250) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!ks_valid && !run_done && !blk_second, "R1", "outputs during mid-run reset",
          {ks_valid, blk_second, run_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!ks_valid && !run_done && !blk_second, "R1", "outputs after mid-run reset",
          {ks_valid, blk_second, run_done}, 0);
    run_case(64'h1357_9BDF_0246_8ACE, 22'h15_0F0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule